// File: doc/BRIEF.md
# Transparent Translation Range Matcher

This block decides, in a single combinational path, whether a 32-bit logical address lies inside one of two transparent translation windows. Each window is held in a 32-bit word. There is one pair of windows for data accesses and a separate pair for instruction fetches. A select input picks which pair is searched. The match compares the address top byte with the window's base byte under a per-bit ignore mask. A window can also be restricted to one privilege level, and it can forbid writes. The two windows are searched in a fixed priority order. The result is a two-bit code: miss, hit with writes allowed, or hit with writes forbidden.

A second combinational path helps software or a sequencer set up a window. From a base address and a size it forms the window word for the selected pair. It also indicates which slot should take that word: slot 1 if it is free, otherwise slot 0 if that is free, otherwise neither. The caller performs the actual register write.

Top module: `ttm_range_matcher`

## Requirements
- R1: A window whose enable bit (bit 15) is 0 never produces a hit; with both selected windows disabled the result is 00.
- R2: The address top byte (bits 31:24) is XORed with the window base byte (bits 31:24). A difference bit whose mask bit (window bits 23:16, same order) is 1 is ignored. The address hits only when no unmasked difference bit remains.
- R3: When the privilege-ignore bit (bit 14) is 0, the window's supervisor bit (bit 13) must equal the supervisor input, or the window misses.
- R4: When the privilege-ignore bit is 1, the supervisor input and the supervisor bit have no effect on the result.
- R5: A hit on a window whose write-protect bit (bit 2) is 1 gives result 10, and a hit with that bit at 0 gives 01. The code 11 never appears.
- R6: Slot 0 of the selected pair takes priority. Slot 1 decides the result only when slot 0 misses.
- R7: With the select input at 1 the data pair is searched, and with it at 0 the instruction pair is searched. The other pair has no effect on the result.
- R8: The built window word has base bits 31:24 of the base input in bits 31:24, bits 31:24 of (base + size - 1) in bits 23:16, bit 15 set, and all other bits 0.
- R9: The slot-write output (bit 1 = slot 1, bit 0 = slot 0) is 10 when selected slot 1 is disabled. It is 01 when slot 1 is enabled and slot 0 is disabled, and 00 when both are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 32 | Logical address under test |
| super_i | input | 1 | Current privilege: 1 = supervisor |
| data_sel_i | input | 1 | 1 = data window pair, 0 = instruction pair |
| dwin0_i | input | 32 | Data window, slot 0 |
| dwin1_i | input | 32 | Data window, slot 1 |
| iwin0_i | input | 32 | Instruction window, slot 0 |
| iwin1_i | input | 32 | Instruction window, slot 1 |
| res_o | output | 2 | 00 miss, 01 hit writable, 10 hit write-protected |
| bld_base_i | input | 32 | Base address for window construction |
| bld_size_i | input | 32 | Region size for window construction |
| bld_word_o | output | 32 | Constructed window word |
| bld_we_o | output | 2 | Slot that should take the constructed word |

## Verification
Several patterns target the address comparison. Exact top-byte equality and a single-bit difference test the base compare. A difference confined to masked bits shows the mask clears only the bits it covers. Patterns that cross both supervisor values with both privilege-ignore settings separate the privilege qualifier from the address match. Overlapping windows with opposite write-protect bits expose the slot priority, and a matching window placed only in the unselected pair exposes the pair select. A pseudo-random sweep over window words and addresses then checks every output against an independent model.

// File: rtl/ttm_pkg.sv
package ttm_pkg;

   typedef enum logic [1:0] {
      TTM_MISS   = 2'b00,
      TTM_HIT_RW = 2'b01,
      TTM_HIT_RO = 2'b10
   } ttm_res_e;

   localparam int TTM_REG_W    = 32;
   localparam int TTM_ADDR_W   = 32;
   localparam int TTM_FIELD_W  = 8;
   localparam int TTM_BASE_LSB = 24;
   localparam int TTM_MASK_LSB = 16;
   localparam int TTM_EN_BIT   = 15;
   localparam int TTM_PIGN_BIT = 14;
   localparam int TTM_SUP_BIT  = 13;
   localparam int TTM_WP_BIT   = 2;

endpackage

// File: rtl/ttm_window_match.sv
module ttm_window_match
   import ttm_pkg::*;
#(
   parameter int REG_W     = TTM_REG_W,
   parameter int ADDR_W    = TTM_ADDR_W,
   parameter int FIELD_W   = TTM_FIELD_W,
   parameter int BASE_LSB  = TTM_BASE_LSB,
   parameter int MASK_LSB  = TTM_MASK_LSB,
   parameter int EN_BIT    = TTM_EN_BIT,
   parameter int PIGN_BIT  = TTM_PIGN_BIT,
   parameter int SUP_BIT   = TTM_SUP_BIT,
   parameter int WP_BIT    = TTM_WP_BIT,
   parameter bit PRIV_QUAL = 1'b1
) (
   input  logic [REG_W-1:0]  win_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              super_i,
   output logic [1:0]        res_o
);

   localparam int ADDR_TOP_LSB = ADDR_W - FIELD_W;

   logic [FIELD_W-1:0] diff_bits;
   logic [FIELD_W-1:0] care_bits;
   logic               addr_hit;
   logic               priv_ok;
   logic               win_on;

   assign diff_bits = addr_i[ADDR_TOP_LSB +: FIELD_W] ^ win_i[BASE_LSB +: FIELD_W];
   assign care_bits = ~win_i[MASK_LSB +: FIELD_W];
   assign addr_hit  = ((diff_bits & care_bits) == '0);
   assign win_on    = win_i[EN_BIT];

   generate
      if (PRIV_QUAL) begin : g_priv
         assign priv_ok = win_i[PIGN_BIT] | (win_i[SUP_BIT] == super_i);
      end else begin : g_nopriv
         logic unused_priv;
         assign unused_priv = super_i ^ win_i[PIGN_BIT] ^ win_i[SUP_BIT];
         assign priv_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      res_o = TTM_MISS;
      if (win_on && addr_hit && priv_ok) begin
         res_o = win_i[WP_BIT] ? TTM_HIT_RO : TTM_HIT_RW;
      end
   end

endmodule

// File: rtl/ttm_priority_chain.sv
module ttm_priority_chain
   import ttm_pkg::*;
#(
   parameter int N_SLOT = 2
) (
   input  logic [2*N_SLOT-1:0] slot_res_i,
   output logic [1:0]          res_o
);

   always_comb begin
      res_o = TTM_MISS;
      for (int s = N_SLOT - 1; s >= 0; s--) begin
         if (slot_res_i[2*s +: 2] != TTM_MISS) begin
            res_o = slot_res_i[2*s +: 2];
         end
      end
   end

endmodule

// File: rtl/ttm_window_builder.sv
module ttm_window_builder
   import ttm_pkg::*;
#(
   parameter int REG_W    = TTM_REG_W,
   parameter int ADDR_W   = TTM_ADDR_W,
   parameter int FIELD_W  = TTM_FIELD_W,
   parameter int BASE_LSB = TTM_BASE_LSB,
   parameter int MASK_LSB = TTM_MASK_LSB,
   parameter int EN_BIT   = TTM_EN_BIT
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] size_i,
   input  logic [REG_W-1:0]  win0_i,
   input  logic [REG_W-1:0]  win1_i,
   output logic [REG_W-1:0]  word_o,
   output logic [1:0]        we_o
);

   localparam int ADDR_TOP_LSB = ADDR_W - FIELD_W;

   logic [ADDR_W-1:0] last_addr;

   assign last_addr = base_i + size_i - {{(ADDR_W-1){1'b0}}, 1'b1};

   always_comb begin
      word_o                         = '0;
      word_o[BASE_LSB +: FIELD_W]    = base_i[ADDR_TOP_LSB +: FIELD_W];
      word_o[MASK_LSB +: FIELD_W]    = last_addr[ADDR_TOP_LSB +: FIELD_W];
      word_o[EN_BIT]                 = 1'b1;
   end

   always_comb begin
      we_o = 2'b00;
      if (!win1_i[EN_BIT]) begin
         we_o = 2'b10;
      end else if (!win0_i[EN_BIT]) begin
         we_o = 2'b01;
      end
   end

endmodule

// File: rtl/ttm_range_matcher.sv
module ttm_range_matcher
   import ttm_pkg::*;
#(
   parameter int REG_W     = TTM_REG_W,
   parameter int ADDR_W    = TTM_ADDR_W,
   parameter int FIELD_W   = TTM_FIELD_W,
   parameter int BASE_LSB  = TTM_BASE_LSB,
   parameter int MASK_LSB  = TTM_MASK_LSB,
   parameter int EN_BIT    = TTM_EN_BIT,
   parameter int PIGN_BIT  = TTM_PIGN_BIT,
   parameter int SUP_BIT   = TTM_SUP_BIT,
   parameter int WP_BIT    = TTM_WP_BIT,
   parameter bit PRIV_QUAL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              super_i,
   input  logic              data_sel_i,
   input  logic [REG_W-1:0]  dwin0_i,
   input  logic [REG_W-1:0]  dwin1_i,
   input  logic [REG_W-1:0]  iwin0_i,
   input  logic [REG_W-1:0]  iwin1_i,
   output logic [1:0]        res_o,
   input  logic [ADDR_W-1:0] bld_base_i,
   input  logic [ADDR_W-1:0] bld_size_i,
   output logic [REG_W-1:0]  bld_word_o,
   output logic [1:0]        bld_we_o
);

   localparam int N_SLOT = 2;

   generate
      if (FIELD_W > ADDR_W) begin : g_chk_field
         $error("field wider than address");
      end
      if (BASE_LSB + FIELD_W > REG_W || MASK_LSB + FIELD_W > REG_W) begin : g_chk_fit
         $error("base or mask field outside the window word");
      end
      if (EN_BIT >= REG_W || PIGN_BIT >= REG_W || SUP_BIT >= REG_W || WP_BIT >= REG_W) begin : g_chk_bits
         $error("flag bit outside the window word");
      end
      if (EN_BIT == PIGN_BIT || EN_BIT == SUP_BIT || EN_BIT == WP_BIT ||
          PIGN_BIT == SUP_BIT || PIGN_BIT == WP_BIT || SUP_BIT == WP_BIT) begin : g_chk_uniq
         $error("flag bits must be distinct");
      end
   endgenerate

   logic [REG_W-1:0]    sel_win [N_SLOT];
   logic [2*N_SLOT-1:0] slot_res;

   always_comb begin
      sel_win[0] = data_sel_i ? dwin0_i : iwin0_i;
      sel_win[1] = data_sel_i ? dwin1_i : iwin1_i;
   end

   generate
      for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
         ttm_window_match #(
            .REG_W    (REG_W),
            .ADDR_W   (ADDR_W),
            .FIELD_W  (FIELD_W),
            .BASE_LSB (BASE_LSB),
            .MASK_LSB (MASK_LSB),
            .EN_BIT   (EN_BIT),
            .PIGN_BIT (PIGN_BIT),
            .SUP_BIT  (SUP_BIT),
            .WP_BIT   (WP_BIT),
            .PRIV_QUAL(PRIV_QUAL)
         ) match_i (
            .win_i  (sel_win[s]),
            .addr_i (addr_i),
            .super_i(super_i),
            .res_o  (slot_res[2*s +: 2])
         );
      end
   endgenerate

   ttm_priority_chain #(
      .N_SLOT(N_SLOT)
   ) chain_i (
      .slot_res_i(slot_res),
      .res_o     (res_o)
   );

   ttm_window_builder #(
      .REG_W   (REG_W),
      .ADDR_W  (ADDR_W),
      .FIELD_W (FIELD_W),
      .BASE_LSB(BASE_LSB),
      .MASK_LSB(MASK_LSB),
      .EN_BIT  (EN_BIT)
   ) build_i (
      .base_i(bld_base_i),
      .size_i(bld_size_i),
      .win0_i(sel_win[0]),
      .win1_i(sel_win[1]),
      .word_o(bld_word_o),
      .we_o  (bld_we_o)
   );

endmodule

// File: rtl/ttm_range_matcher_chk.sv
module ttm_range_matcher_chk
   import ttm_pkg::*;
(
   input logic        data_sel_i,
   input logic [31:0] dwin0_i,
   input logic [31:0] dwin1_i,
   input logic [31:0] iwin0_i,
   input logic [31:0] iwin1_i,
   input logic [1:0]  res_o,
   input logic [31:0] bld_word_o,
   input logic [1:0]  bld_we_o
);

   logic [31:0] w0;
   logic [31:0] w1;

   assign w0 = data_sel_i ? dwin0_i : iwin0_i;
   assign w1 = data_sel_i ? dwin1_i : iwin1_i;

   always_comb begin
      // R5
      res_code_legal_chk: assert (res_o != 2'b11);
      // R1
      both_off_miss_chk: assert (!(!w0[TTM_EN_BIT] && !w1[TTM_EN_BIT]) || res_o == TTM_MISS);
      // R6
      slot0_ro_wins_chk: assert (!(w0[TTM_EN_BIT] && !w1[TTM_EN_BIT] && !w0[TTM_WP_BIT]) || res_o != TTM_HIT_RO);
      // R9
      slot_we_onehot_chk: assert ($onehot0(bld_we_o));
      // R9
      slot_we_free_chk: assert (!(bld_we_o[1] && w1[TTM_EN_BIT]) && !(bld_we_o[0] && (w0[TTM_EN_BIT] || !w1[TTM_EN_BIT])));
      // R8
      built_enabled_chk: assert (bld_word_o[TTM_EN_BIT] && bld_word_o[TTM_WP_BIT] == 1'b0);
   end

endmodule

bind ttm_range_matcher ttm_range_matcher_chk chk_i (
   .data_sel_i(data_sel_i),
   .dwin0_i   (dwin0_i),
   .dwin1_i   (dwin1_i),
   .iwin0_i   (iwin0_i),
   .iwin1_i   (iwin1_i),
   .res_o     (res_o),
   .bld_word_o(bld_word_o),
   .bld_we_o  (bld_we_o)
);

// File: tb/ttm_range_matcher_tb.sv
module ttm_range_matcher_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [31:0] addr = '0;
   logic        sup = 1'b0;
   logic        dsel = 1'b0;
   logic [31:0] dw0 = '0, dw1 = '0, iw0 = '0, iw1 = '0;
   logic [31:0] bbase = '0, bsize = 32'h1;
   logic [1:0]  res;
   logic [31:0] bword;
   logic [1:0]  bwe;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [1:0]  res;
      logic [1:0]  we;
      logic [31:0] word;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ttm_range_matcher dut_i (
      .addr_i    (addr),
      .super_i   (sup),
      .data_sel_i(dsel),
      .dwin0_i   (dw0),
      .dwin1_i   (dw1),
      .iwin0_i   (iw0),
      .iwin1_i   (iw1),
      .res_o     (res),
      .bld_base_i(bbase),
      .bld_size_i(bsize),
      .bld_word_o(bword),
      .bld_we_o  (bwe)
   );

   function automatic logic [31:0] mkwin(logic [7:0] b, logic [7:0] m, bit en, bit pign, bit s, bit wp);
      logic [31:0] w;
      w = {b, m, 16'h0};
      w[15] = en; w[14] = pign; w[13] = s; w[2] = wp;
      return w;
   endfunction

   function automatic logic [1:0] ref_one(logic [31:0] w, logic [31:0] a, logic s);
      if (!w[15]) return 2'b00;
      if (((a[31:24] ^ w[31:24]) & ~w[23:16]) != 8'h00) return 2'b00;
      if (!w[14] && (w[13] != s)) return 2'b00;
      return w[2] ? 2'b10 : 2'b01;
   endfunction

   function automatic logic [1:0] ref_res();
      logic [31:0] a0, a1;
      logic [1:0]  r;
      a0 = dsel ? dw0 : iw0;
      a1 = dsel ? dw1 : iw1;
      r = ref_one(a0, addr, sup);
      if (r == 2'b00) r = ref_one(a1, addr, sup);
      return r;
   endfunction

   function automatic logic [1:0] ref_we();
      logic [31:0] a0, a1;
      a0 = dsel ? dw0 : iw0;
      a1 = dsel ? dw1 : iw1;
      if (!a1[15]) return 2'b10;
      if (!a0[15]) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [31:0] ref_word();
      logic [31:0] last;
      last = bbase + bsize - 32'd1;
      return {bbase[31:24], last[31:24], 16'h8000};
   endfunction

   // Inputs must be set by the caller after a posedge; expected item is queued.
   task automatic push(string tag, logic [1:0] exp_res);
      exp_t e;
      e.res = exp_res; e.we = ref_we(); e.word = ref_word(); e.tag = tag;
      sb_q.push_back(e);
      @(posedge clk);
      #1;
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_tests++;
            if (res !== e.res || bwe !== e.we || bword !== e.word) begin
               n_fail++;
               $display("FAIL %s: res=%b we=%b word=%h expected res=%b we=%b word=%h",
                        e.tag, res, bwe, bword, e.res, e.we, e.word);
            end
         end
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD*100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : driver
      @(posedge clk); #1;
      // R1 R9: everything off
      push("R1 all windows off", 2'b00);
      // R2: exact top byte
      dsel = 1; addr = 32'h4012_3456; dw0 = mkwin(8'h40, 8'h00, 1, 1, 0, 0);
      push("R2 exact byte hit", 2'b01);
      addr = 32'h4112_3456;
      push("R2 one-bit difference miss", 2'b00);
      dw0 = mkwin(8'h40, 8'h0F, 1, 1, 0, 0); addr = 32'h4A00_0000;
      push("R2 masked difference hit", 2'b01);
      addr = 32'h5A00_0000;
      push("R2 unmasked difference miss", 2'b00);
      // R1: disabled but matching
      dw0 = mkwin(8'h40, 8'h00, 0, 1, 0, 0); addr = 32'h4000_0000;
      push("R1 disabled window miss", 2'b00);
      // R3
      dw0 = mkwin(8'h40, 8'h00, 1, 0, 1, 0); sup = 0;
      push("R3 user vs supervisor window miss", 2'b00);
      sup = 1;
      push("R3 supervisor match hit", 2'b01);
      dw0 = mkwin(8'h40, 8'h00, 1, 0, 0, 0);
      push("R3 supervisor vs user window miss", 2'b00);
      // R4
      dw0 = mkwin(8'h40, 8'h00, 1, 1, 0, 0); sup = 1;
      push("R4 privilege ignored sup=1", 2'b01);
      dw0 = mkwin(8'h40, 8'h00, 1, 1, 1, 0); sup = 0;
      push("R4 privilege ignored sup=0", 2'b01);
      // R5
      dw0 = mkwin(8'h40, 8'h00, 1, 1, 0, 1);
      push("R5 write-protected hit", 2'b10);
      // R6
      dw1 = mkwin(8'h40, 8'h00, 1, 1, 0, 0);
      push("R6 slot0 protected wins over slot1", 2'b10);
      dw0 = mkwin(8'h77, 8'h00, 1, 1, 0, 1);
      push("R6 slot1 used when slot0 misses", 2'b01);
      dw0 = mkwin(8'h40, 8'h00, 1, 1, 0, 0); dw1 = mkwin(8'h40, 8'h00, 1, 1, 0, 1);
      push("R6 slot0 writable wins", 2'b01);
      // R7
      dw0 = '0; dw1 = '0; iw0 = mkwin(8'h40, 8'h00, 1, 1, 0, 1); dsel = 1;
      push("R7 data pair selected ignores instr", 2'b00);
      dsel = 0;
      push("R7 instruction pair selected", 2'b10);
      iw0 = '0; dw0 = mkwin(8'h40, 8'h00, 1, 1, 0, 0);
      push("R7 instr pair ignores data", 2'b00);
      // R8 R9
      dsel = 1; dw0 = '0; dw1 = mkwin(8'h01, 8'h00, 1, 1, 0, 0); addr = 32'h0;
      bbase = 32'h1000_0000; bsize = 32'h0200_0000;
      if (ref_word() !== 32'h1011_8000) $display("bench model mismatch R8");
      push("R8 R9 build into slot0", 2'b00);
      dw0 = mkwin(8'hAA, 8'h00, 1, 1, 0, 0);
      push("R9 both slots busy", 2'b00);
      dw1 = '0; bbase = 32'hFF80_0000; bsize = 32'h0100_0000;
      push("R8 R9 wrapping end, slot1 free", 2'b00);
      // sweep against model
      for (int k = 0; k < 60; k++) begin
         addr = $urandom; sup = $urandom_range(1, 0); dsel = $urandom_range(1, 0);
         dw0 = $urandom; dw1 = $urandom; iw0 = $urandom; iw1 = $urandom;
         dw0[31:24] = addr[31:24] ^ (8'h1 << (k % 8));
         iw1[31:24] = addr[31:24];
         bbase = $urandom; bsize = $urandom;
         push("R2 R3 R5 R6 R7 sweep", ref_res());
      end
      @(posedge clk); @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule